// File: doc/BRIEF.md
# Timeslot Signaling Capture Buffer

This block keeps a snapshot of one multiframe's worth of per-timeslot signaling. A serial stream arrives one bit per clock. A frame-sync pulse marks the first bit of timeslot 0. Every timeslot is eight bits wide. The last four bits of each timeslot carry that timeslot's signaling nibble. As each timeslot completes, the block writes the nibble into a 32-entry store whose index equals the timeslot number. The store therefore always holds the most recent signaling seen for every channel.

A simple processor port sits beside the serial path. A read strobe returns the addressed entry one cycle later, with its upper four bits at zero. A write strobe overwrites the low nibble of the addressed entry. Incoming serial traffic always refreshes the store, so a processor write holds only until the timeslot it targets passes again. When both sides hit the same entry in the same cycle, the serial capture takes priority.

Both the serial stream and the processor port are plain strobed interfaces with no back-pressure. The block accepts one serial bit on every clock and completes every processor access in a single cycle, so neither side ever stalls.

Top module: `sig_slot_buffer`

## Requirements
- R1: After reset every entry holds zero, and `cpu_rdata` is zero.
- R2: Entry N receives the signaling of timeslot N. Timeslot N is the N-th group of eight bits counted from the cycle in which `fsync` is high, and that cycle is bit 0 of timeslot 0. Without a new `fsync`, the count wraps from timeslot 31 back to timeslot 0.
- R3: The nibble is made of bits 4 to 7 of the timeslot. Bit 4 lands in entry bit 3 (MSB first) and bit 7 lands in entry bit 0. Bits 0 to 3 of each timeslot are ignored.
- R4: An entry is written on the clock edge that samples bit 7 of its timeslot. A read issued in the next cycle returns the new value.
- R5: `fsync` high in any cycle restarts counting at timeslot 0, bit 0. A timeslot cut short this way is not written, and its entry keeps its old value.
- R6: `cpu_wr` high writes `cpu_wdata[3:0]` into entry `cpu_addr`. `cpu_wdata[7:4]` is ignored.
- R7: `cpu_rd` high loads `cpu_rdata` at the next edge with `{4'b0000, entry[cpu_addr]}`. While `cpu_rd` is low, `cpu_rdata` holds its value.
- R8: If a processor write and a serial capture target the same entry in the same cycle, the entry takes the serial nibble.
- R9: After reset, no entry is written from the serial input until the first `fsync` has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | High during bit 0 of timeslot 0 |
| sig_in | input | 1 | Serial signaling data |
| cpu_addr | input | 5 | Entry index for a processor read or write |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Processor write data; only the low nibble is stored |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_rdata | output | 8 | Read data, loaded one cycle after `cpu_rd` |

## Verification
The hardest case to reach is the collision between a processor write and a serial capture. The write must arrive in the exact cycle that samples bit 7 of the targeted timeslot. The bench reaches it by counting bit positions from its own `fsync` pulse and issuing the write at cycle 8·k+7 of the frame. It then reads the entry back and expects the serial nibble. Two further cases need precise timing. A processor write is read back before its timeslot comes round again. An early `fsync` cuts a timeslot off at bit 5, after which the bench checks that the interrupted entry kept its previous value.

// File: rtl/sigbuf_pkg.sv
package sigbuf_pkg;
  localparam int DEF_SLOTS     = 32;
  localparam int DEF_SLOT_BITS = 8;
  localparam int DEF_SIG_W     = 4;
  localparam int DEF_DATA_W    = 8;

  typedef enum logic {
    SYNC_HUNT   = 1'b0,
    SYNC_LOCKED = 1'b1
  } sync_state_e;
endpackage

// File: rtl/sigbuf_slot_timer.sv
module sigbuf_slot_timer
  import sigbuf_pkg::*;
#(
  parameter int SLOTS     = DEF_SLOTS,
  parameter int SLOT_BITS = DEF_SLOT_BITS,
  localparam int IDX_W    = $clog2(SLOTS),
  localparam int BIT_W    = $clog2(SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic [BIT_W-1:0] cur_bit,
  output logic [IDX_W-1:0] cur_slot,
  output logic             locked,
  output logic             slot_end
);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(SLOT_BITS - 1);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(SLOTS - 1);

  logic [BIT_W-1:0] bit_q;
  logic [IDX_W-1:0] slot_q;
  sync_state_e      sync_q;

  // A frame sync pulse overrides the running count in its own cycle.
  always_comb begin
    cur_bit  = fsync ? '0 : bit_q;
    cur_slot = fsync ? '0 : slot_q;
    locked   = (sync_q == SYNC_LOCKED) || fsync;
    slot_end = (cur_bit == LAST_BIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q  <= '0;
      slot_q <= '0;
      sync_q <= SYNC_HUNT;
    end else begin
      if (fsync) sync_q <= SYNC_LOCKED;
      if (slot_end) begin
        bit_q  <= '0;
        slot_q <= (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
      end else begin
        bit_q  <= cur_bit + 1'b1;
        slot_q <= cur_slot;
      end
    end
  end

  // R5: a sync pulse restarts the count at slot 0
  assert_fsync_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (bit_q == BIT_W'(1) && slot_q == '0));

  // R2: the bit counter wraps to zero after the last bit of a slot
  assert_bit_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && bit_q == LAST_BIT) |=> (bit_q == '0));

  // R2: the slot index advances by one at a slot boundary
  assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fsync && bit_q == LAST_BIT && slot_q != LAST_SLOT) |=> (slot_q == $past(slot_q) + 1'b1));
endmodule

// File: rtl/sigbuf_nibble_collect.sv
module sigbuf_nibble_collect
  import sigbuf_pkg::*;
#(
  parameter int SLOT_BITS = DEF_SLOT_BITS,
  parameter int SIG_W     = DEF_SIG_W,
  localparam int BIT_W    = $clog2(SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_in,
  input  logic [BIT_W-1:0] cur_bit,
  output logic [SIG_W-1:0] nibble
);
  localparam logic [BIT_W-1:0] FIELD_START = BIT_W'(SLOT_BITS - SIG_W);

  logic [SIG_W-2:0] sh_q;
  logic             in_field;

  assign in_field = (cur_bit >= FIELD_START);
  // The last bit joins the assembled word combinationally, so the nibble
  // is complete in the cycle that samples the final slot bit.
  assign nibble = {sh_q, sig_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (in_field) begin
      sh_q <= {sh_q[SIG_W-3:0], sig_in};
    end
  end

  // R3: bits before the signaling field leave the shift register alone
  assert_prefix_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_field |=> $stable(sh_q));
endmodule

// File: rtl/sigbuf_entry_store.sv
module sigbuf_entry_store
  import sigbuf_pkg::*;
#(
  parameter int SLOTS   = DEF_SLOTS,
  parameter int SIG_W   = DEF_SIG_W,
  parameter int DATA_W  = DEF_DATA_W,
  localparam int IDX_W  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_we,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [SIG_W-1:0]  cap_nib,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [SIG_W-1:0]  host_nib,
  output logic [DATA_W-1:0] rdata
);
  logic [SIG_W-1:0] ent [SLOTS];

  for (genvar e = 0; e < SLOTS; e++) begin : g_entry
    logic hit_cap, hit_host;
    assign hit_cap  = cap_we  && (cap_idx  == IDX_W'(e));
    assign hit_host = host_we && (host_idx == IDX_W'(e));
    // Serial capture has priority over the processor.
    always_ff @(posedge clk) begin
      if (!rst_n)        ent[e] <= '0;
      else if (hit_cap)  ent[e] <= cap_nib;
      else if (hit_host) ent[e] <= host_nib;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata <= '0;
    else if (host_re) rdata <= {{(DATA_W-SIG_W){1'b0}}, ent[host_idx]};
  end

  // R4: a captured nibble is in its entry after the edge
  assert_capture_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |=> (ent[$past(cap_idx)] == $past(cap_nib)));

  // R6: a processor write without a collision lands in its entry
  assert_host_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !(cap_we && cap_idx == host_idx)) |=> (ent[$past(host_idx)] == $past(host_nib)));

  // R8: on a collision the serial nibble is kept
  assert_serial_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && cap_we && cap_idx == host_idx) |=> (ent[$past(host_idx)] == $past(cap_nib)));

  // R7: read data holds while no read is requested
  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !host_re |=> $stable(rdata));
endmodule

// File: rtl/sig_slot_buffer.sv
module sig_slot_buffer
  import sigbuf_pkg::*;
#(
  parameter int SLOTS     = DEF_SLOTS,
  parameter int SLOT_BITS = DEF_SLOT_BITS,
  parameter int SIG_W     = DEF_SIG_W,
  parameter int DATA_W    = DEF_DATA_W,
  localparam int IDX_W    = $clog2(SLOTS),
  localparam int BIT_W    = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              sig_in,
  input  logic [IDX_W-1:0]  cpu_addr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata
);
  logic [BIT_W-1:0] cur_bit;
  logic [IDX_W-1:0] cur_slot;
  logic             locked;
  logic             slot_end;
  logic [SIG_W-1:0] nibble;
  logic             cap_we;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^cpu_wdata[DATA_W-1:SIG_W];

  sigbuf_slot_timer #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .fsync    (fsync),
    .cur_bit  (cur_bit),
    .cur_slot (cur_slot),
    .locked   (locked),
    .slot_end (slot_end)
  );

  sigbuf_nibble_collect #(.SLOT_BITS(SLOT_BITS), .SIG_W(SIG_W)) u_collect (
    .clk     (clk),
    .rst_n   (rst_n),
    .sig_in  (sig_in),
    .cur_bit (cur_bit),
    .nibble  (nibble)
  );

  assign cap_we = locked && slot_end;

  sigbuf_entry_store #(.SLOTS(SLOTS), .SIG_W(SIG_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_we   (cap_we),
    .cap_idx  (cur_slot),
    .cap_nib  (nibble),
    .host_we  (cpu_wr),
    .host_re  (cpu_rd),
    .host_idx (cpu_addr),
    .host_nib (cpu_wdata[SIG_W-1:0]),
    .rdata    (cpu_rdata)
  );

  // R7: the upper bits of read data are always zero
  assert_rdata_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd |=> (cpu_rdata[DATA_W-1:SIG_W] == '0));

  // R9: no capture before the first sync pulse
  assert_no_capture_unlocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked) |-> !cap_we);
endmodule

// File: tb/sig_slot_buffer_tb.sv
module sig_slot_buffer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic       sig_in = 1'b0;
  logic [4:0] cpu_addr = '0;
  logic       cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic       cpu_rd = 1'b0;
  logic [7:0] cpu_rdata;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [3:0] fr [32];
  logic       pend = 1'b0;
  logic [7:0] pend_exp = '0;
  string      pend_tag = "";

  // Each vector: base nibble [7:4], step [3:0]; slot s gets base + s*step.
  localparam logic [7:0] VEC [4] = '{8'h01, 8'hA3, 8'h5F, 8'hC7};

  always #4 clk = ~clk;

  sig_slot_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .sig_in(sig_in),
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: cpu_rdata=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Serial bit at frame position i: bits 0..3 are junk, bits 4..7 carry fr[slot] MSB first (R3).
  function automatic logic fbit(input int i);
    int s = (i / 8) % 32;
    int b = i % 8;
    if (b < 4) return ((i * 7 + 3) % 5) < 2;
    return fr[s][7 - b];
  endfunction

  // One clock: called at a falling edge; checks the previous read, drives, advances.
  task automatic cyc(input logic fs, input logic b, input logic rd, input logic wr,
                     input logic [4:0] ad, input logic [7:0] wd,
                     input logic [7:0] exp, input string tag);
    if (pend) chk(cpu_rdata, pend_exp, pend_tag);
    pend = rd;
    pend_exp = exp;
    pend_tag = tag;
    fsync = fs; sig_in = b; cpu_rd = rd; cpu_wr = wr; cpu_addr = ad; cpu_wdata = wd;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [3:0] old3;
    logic [7:0] last_rd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: every entry reads zero after reset
    for (int a = 0; a < 32; a++) cyc(0, a[0], 1, 0, a[4:0], 8'h00, 8'h00, "R1 reset entry");
    // R9: serial traffic without sync must not write anything
    for (int k = 0; k < 300; k++) cyc(0, k[1] ^ k[3], 0, 0, 5'd0, 8'h00, 8'h00, "");
    for (int a = 0; a < 32; a++) cyc(0, 1'b1, 1, 0, a[4:0], 8'h00, 8'h00, "R9 unlocked entry");

    // Table walk, R2 R3 R4 R7: send each frame twice, read all entries during the second.
    for (int v = 0; v < 4; v++) begin
      for (int s = 0; s < 32; s++) fr[s] = VEC[v][7:4] + 4'(s) * VEC[v][3:0];
      for (int p = 0; p < 2; p++) begin
        for (int i = 0; i < 256; i++) begin
          logic r;
          r = (p == 1) && (i < 32);
          cyc(i == 0, fbit(i), r, 0, 5'(i), 8'h00, {4'h0, fr[i % 32]}, "R2 R3 R4 R7 table");
        end
      end
    end

    // Processor access within a live frame: R6, R4 overwrite, R8 collision.
    for (int i = 0; i < 256; i++) begin
      if (i == 10)       cyc(0, fbit(i), 0, 1, 5'd20, {4'hF, ~fr[20]}, 8'h00, "");
      else if (i == 11)  cyc(0, fbit(i), 1, 0, 5'd20, 8'h00, {4'h0, ~fr[20]}, "R6 R7 write readback");
      else if (i == 170) cyc(0, fbit(i), 1, 0, 5'd20, 8'h00, {4'h0, fr[20]}, "R4 serial refresh");
      else if (i == 207) cyc(0, fbit(i), 0, 1, 5'd25, {4'hA, ~fr[25]}, 8'h00, "");
      else if (i == 209) cyc(0, fbit(i), 1, 0, 5'd25, 8'h00, {4'h0, fr[25]}, "R8 collision");
      else               cyc(i == 0, fbit(i), 0, 0, 5'd0, 8'h00, 8'h00, "");
    end
    cyc(0, 1'b0, 0, 0, 5'd0, 8'h00, 8'h00, "");
    last_rd = cpu_rdata;
    cyc(0, 1'b1, 0, 0, 5'd3, 8'h00, 8'h00, "");
    chk(cpu_rdata, last_rd, "R7 hold without read");

    // R5: early sync cuts slot 3 at bit 5; entry 3 keeps its old value.
    old3 = fr[3];
    for (int s = 0; s < 32; s++) fr[s] = fr[s] ^ 4'h5;
    for (int i = 0; i < 30; i++) cyc(i == 0, fbit(i), 0, 0, 5'd0, 8'h00, 8'h00, "");
    for (int j = 0; j < 40; j++) begin
      if (j == 2)       cyc(0, fbit(j), 1, 0, 5'd3, 8'h00, {4'h0, old3}, "R5 cut slot kept");
      else if (j == 4)  cyc(0, fbit(j), 1, 0, 5'd2, 8'h00, {4'h0, fr[2]}, "R5 prior slot written");
      else if (j == 9)  cyc(0, fbit(j), 1, 0, 5'd0, 8'h00, {4'h0, fr[0]}, "R5 restart slot 0");
      else              cyc(j == 0, fbit(j), 0, 0, 5'd0, 8'h00, 8'h00, "");
    end
    cyc(0, 1'b0, 0, 0, 5'd0, 8'h00, 8'h00, "");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule